// File: doc/BRIEF.md
# Trigger Qualifier with Retriggerable Lockout

This block sits between an asynchronous external trigger line and the RF pulse generator that runs on the sampling clock. It brings the raw trigger into the clock domain through a two-flop synchronizer and treats only rising edges as events. Each event is then tested against a lockout window and the external health inputs before it is passed on.

Every edge restarts the lockout window, whether the edge is taken or thrown away. A rebounding or chattering input therefore keeps the lockout open, and a trigger stream faster than the window length gets no trigger through. An accepted edge produces a pulse one sample wide. It also raises a gate request that lasts as long as the window, and it advances a chop divider that flags every Nth accepted trigger. A counter records every edge that was not passed on.

The window length is a cycle count. It is clamped to the span that 0.5 µs to 10 µs covers at the configured sample rate.

Top module: `trig_qualifier`

## Requirements
- R1: A rising edge on `trig_raw` that is accepted appears on `trig_pulse` after the third rising clock edge that follows the input change. A level held high gives only one event, and a falling edge gives none.
- R2: `trig_pulse` is high for exactly one clock cycle for each accepted edge.
- R3: An edge is accepted only if `pwr_ok` and `prot_done` are both high in the cycle in which the edge is detected. Otherwise it is dropped.
- R4: An edge detected while the lockout window is active is dropped.
- R5: Every detected edge reloads the window to its full length, whether the edge is accepted, dropped by R3 or dropped by R4. A trigger train whose edge spacing is no larger than the window passes only its first edge.
- R6: The window length L is `blank_len` clamped to the range [SAMPLE_MHZ/2, SAMPLE_MHZ*10], sampled at the detected edge. The window covers the L cycles that follow the detection cycle, so the next edge is accepted only if its spacing is at least L+1 cycles.
- R7: `gate_req` rises together with an accepted `trig_pulse` and falls in the cycle in which the window expires. A retrigger inside the window extends it.
- R8: `chop` is high together with `trig_pulse` on every Nth accepted trigger. N is 10 after reset, and the accepted-trigger count restarts at zero after reset.
- R9: A write (`div_wr` high) of `div_val` in the range 2 to 254 becomes N at the next chop wrap. A write of any other value is ignored.
- R10: `lost_cnt` rises by exactly one for each detected edge that is not accepted, and it wraps at its width. It holds its value otherwise.
- R11: While reset is asserted, `trig_pulse`, `gate_req`, `chop` and `lost_cnt` are zero and the window is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_raw | input | 1 | Unsynchronized external trigger |
| pwr_ok | input | 1 | Power health, must be high to accept |
| prot_done | input | 1 | Protection interval elapsed, must be high to accept |
| blank_len | input | LEN_W | Requested lockout length in cycles (clamped) |
| div_wr | input | 1 | Write strobe for the chop divisor |
| div_val | input | 8 | Chop divisor value written on `div_wr` |
| trig_pulse | output | 1 | One-cycle qualified trigger |
| gate_req | output | 1 | Gate request held for the window after an accept |
| chop | output | 1 | Marks every Nth accepted trigger |
| lost_cnt | output | LOST_W | Count of dropped trigger edges |

## Verification
The bench fires trains whose edge spacing is exactly L and exactly L+1 cycles, at both clamp limits. A design that counts the window one cycle short or long, or that skips the clamp, shows up here as an accepted or dropped pulse in the wrong place. Bursts inside the window catch a design that lets the lockout expire instead of reloading it. Health-rejected edges catch a design that skips the reload for them or fails to count them as lost. Divisor writes of 1, 255 and 3 made mid-count catch a divider that applies a write immediately or accepts out-of-range values, because `chop` then lands on the wrong trigger.

// File: rtl/trq_pkg.sv
package trq_pkg;

    localparam int          DIV_W   = 8;
    localparam logic [7:0]  DIV_RST = 8'd10;
    localparam logic [7:0]  DIV_LO  = 8'd2;
    localparam logic [7:0]  DIV_HI  = 8'd254;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] active;
        logic [DIV_W-1:0] pending;
        logic             chop;
    } chop_st_t;

endpackage

// File: rtl/trq_sync.sv
module trq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic edge_o
);

    // sh[0..STAGES-1] synchronizer chain, sh[STAGES] previous synchronized level
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R1

endmodule

// File: rtl/trq_blank.sv
module trq_blank #(
    parameter int LEN_W   = 16,
    parameter int WIN_MIN = 100,
    parameter int WIN_MAX = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             expire_o
);

    localparam int               CNT_W = $clog2(WIN_MAX + 1);
    localparam logic [LEN_W-1:0] LO    = LEN_W'(WIN_MIN);
    localparam logic [LEN_W-1:0] HI    = LEN_W'(WIN_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } blank_st_t;

    blank_st_t        st_d, st_q;
    logic [LEN_W-1:0] len_c;

    always_comb begin
        if (len_i < LO)      len_c = LO;
        else if (len_i > HI) len_c = HI;
        else                 len_c = len_i;

        st_d = st_q;
        if (edge_i)                st_d.cnt = CNT_W'(len_c);
        else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = (st_q.cnt != '0);
    assign expire_o = !edge_i && (st_q.cnt == CNT_W'(1));

    AST_WINDOW_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (int'(st_q.cnt) >= WIN_MIN && int'(st_q.cnt) <= WIN_MAX)); // R6

    AST_WINDOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> busy_o); // R5

endmodule

// File: rtl/trq_chop.sv
module trq_chop
    import trq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] wr_val_i,
    output logic             chop_o
);

    chop_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.chop = 1'b0;
        if (step_i) begin
            if (st_q.cnt == st_q.active - DIV_W'(1)) begin
                st_d.chop   = 1'b1;
                st_d.cnt    = '0;
                st_d.active = st_q.pending;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
        if (wr_i && wr_val_i >= DIV_LO && wr_val_i <= DIV_HI)
            st_d.pending = wr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.active  <= DIV_RST;
            st_q.pending <= DIV_RST;
            st_q.chop    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chop_o = st_q.chop;

    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active >= DIV_LO && st_q.active <= DIV_HI); // R9

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.active); // R8

endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier #(
    parameter int SAMPLE_MHZ  = 200,
    parameter int LEN_W       = 16,
    parameter int LOST_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_raw,
    input  logic              pwr_ok,
    input  logic              prot_done,
    input  logic [LEN_W-1:0]  blank_len,
    input  logic              div_wr,
    input  logic [7:0]        div_val,
    output logic              trig_pulse,
    output logic              gate_req,
    output logic              chop,
    output logic [LOST_W-1:0] lost_cnt
);

    localparam int WIN_MIN = SAMPLE_MHZ / 2;
    localparam int WIN_MAX = SAMPLE_MHZ * 10;

    typedef struct packed {
        logic              pulse;
        logic              gate;
        logic [LOST_W-1:0] lost;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    edge_seen, busy, expire, accept;

    trq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (trig_raw),
        .edge_o (edge_seen)
    );

    trq_blank #(.LEN_W(LEN_W), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_seen),
        .len_i    (blank_len),
        .busy_o   (busy),
        .expire_o (expire)
    );

    assign accept = edge_seen & ~busy & pwr_ok & prot_done;

    trq_chop u_chop (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (accept),
        .wr_i     (div_wr),
        .wr_val_i (div_val),
        .chop_o   (chop)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = accept;
        if (accept)      st_d.gate = 1'b1;
        else if (expire) st_d.gate = 1'b0;
        if (edge_seen && !accept)
            st_d.lost = st_q.lost + LOST_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_pulse = st_q.pulse;
    assign gate_req   = st_q.gate;
    assign lost_cnt   = st_q.lost;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse); // R2

    AST_HEALTH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(pwr_ok && prot_done)); // R3

    AST_LOCKOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && busy) |=> (!trig_pulse && lost_cnt == $past(lost_cnt) + LOST_W'(1))); // R4

    AST_GATE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        gate_req |-> busy); // R7

    AST_CHOP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        chop |-> trig_pulse); // R8

    AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_seen |=> $stable(lost_cnt)); // R10

endmodule

// File: tb/tb_trig_qualifier.sv
module tb_trig_qualifier;

    localparam int MHZ    = 20;
    localparam int LEN_W  = 16;
    localparam int LOST_W = 16;
    localparam int WMIN   = MHZ / 2;
    localparam int WMAX   = MHZ * 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_raw = 1'b0;
    logic              pwr_ok = 1'b0;
    logic              prot_done = 1'b0;
    logic [LEN_W-1:0]  blank_len = 16'd20;
    logic              div_wr = 1'b0;
    logic [7:0]        div_val = 8'd0;
    logic              trig_pulse, gate_req, chop;
    logic [LOST_W-1:0] lost_cnt;

    trig_qualifier #(.SAMPLE_MHZ(MHZ), .LEN_W(LEN_W), .LOST_W(LOST_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .pwr_ok(pwr_ok),
        .prot_done(prot_done), .blank_len(blank_len), .div_wr(div_wr),
        .div_val(div_val), .trig_pulse(trig_pulse), .gate_req(gate_req),
        .chop(chop), .lost_cnt(lost_cnt)
    );

    always #2.5 clk = ~clk;

    int    vectors = 0, miscompares = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    // behavioural reference state
    int h1, h2, h3, m_blank, m_lost, m_cnt, m_div, m_pend, m_len;
    bit m_pulse, m_gate, m_chop, m_edge, m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0; m_blank = 0; m_lost = 0; m_cnt = 0;
            m_div = 10; m_pend = 10; m_pulse = 0; m_gate = 0; m_chop = 0;
        end else begin
            m_edge = (h2 == 1) && (h3 == 0);
            m_len  = int'(blank_len);
            if (m_len < WMIN) m_len = WMIN;
            if (m_len > WMAX) m_len = WMAX;
            m_acc = 0; m_pulse = 0; m_chop = 0;
            if (m_edge) begin
                if (m_blank == 0 && pwr_ok && prot_done) m_acc = 1;
                else m_lost = (m_lost + 1) % 65536;
                m_blank = m_len;
            end else if (m_blank > 0) begin
                m_blank = m_blank - 1;
            end
            if (m_acc) m_gate = 1;
            else if (m_blank == 0) m_gate = 0;
            if (m_acc) begin
                m_pulse = 1;
                if (m_cnt == m_div - 1) begin
                    m_chop = 1; m_cnt = 0; m_div = m_pend;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (div_wr && div_val >= 8'd2 && div_val <= 8'd254) m_pend = int'(div_val);
            h3 = h2; h2 = h1; h1 = int'(trig_raw);
        end
    end

    task automatic cmp(string what, int act, int exp_v);
        vectors++;
        if (act != exp_v) begin
            miscompares++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", cur_req, what, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cmp("trig_pulse", int'(trig_pulse), int'(m_pulse));
            cmp("gate_req",   int'(gate_req),   int'(m_gate));
            cmp("chop",       int'(chop),       int'(m_chop));
            cmp("lost_cnt",   int'(lost_cnt),   m_lost);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // rising edge then idle; edge-to-edge spacing equals gap
    task automatic fire(int gap);
        trig_raw = 1'b1; cyc(2);
        trig_raw = 1'b0; cyc(gap - 2);
    endtask

    task automatic wr_div(int v);
        div_val = 8'(v); div_wr = 1'b1; cyc(1); div_wr = 1'b0;
    endtask

    initial begin
        cur_req = "R11";                      // reset values
        cyc(5);
        rst_n = 1'b1; pwr_ok = 1'b1; prot_done = 1'b1;
        cyc(3);

        cur_req = "R1 R2 R7";                 // held level gives one pulse, gate spans window
        blank_len = 16'd20;
        trig_raw = 1'b1; cyc(40); trig_raw = 1'b0; cyc(30);

        cur_req = "R4 R5 R10";                // burst inside window keeps lockout open
        blank_len = 16'd15;
        repeat (12) fire(8);
        cyc(30);

        cur_req = "R3 R5 R10";                // health rejects still reload window
        pwr_ok = 1'b0; fire(30); pwr_ok = 1'b1;
        prot_done = 1'b0; fire(30); prot_done = 1'b1;
        fire(30);
        pwr_ok = 1'b0; fire(6); pwr_ok = 1'b1; fire(6); cyc(30);

        cur_req = "R6";                       // clamp and L / L+1 spacing
        blank_len = 16'd3;
        repeat (5) fire(WMIN + 1);
        repeat (4) fire(WMIN);
        cyc(30);
        blank_len = 16'd5000;
        repeat (3) fire(WMAX);
        cyc(WMAX + 10);
        repeat (3) fire(WMAX + 1);
        cyc(WMAX + 10);

        cur_req = "R8 R9";                    // chop every Nth, deferred divisor writes
        blank_len = 16'd10;
        repeat (23) fire(13);
        wr_div(3); cyc(2);
        repeat (12) fire(13);
        wr_div(1); cyc(2);
        repeat (8) fire(13);
        wr_div(255); cyc(2);
        repeat (8) fire(13);
        wr_div(2); cyc(2);
        repeat (8) fire(13);

        cur_req = "R1 R3 R4 R5 R10";          // random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) trig_raw = ~trig_raw;
            pwr_ok    = ($urandom_range(0, 7) != 0);
            prot_done = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 50) == 0) blank_len = LEN_W'($urandom_range(0, 40));
            cyc(1);
        end
        trig_raw = 1'b0;
        cyc(WMAX + 5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog %s actual timeout expected completion", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule